// File: doc/BRIEF.md
# Banked Deep LUT-Style RAM

This block builds one deep, wide random-access memory out of a grid of small 16-word by 4-bit storage cells. The low four address bits, the write data and the write request fan out to every cell. The address bits above bit 3 are decoded into a one-hot bank select. Each bank's write-port enable is its own select ANDed with the write request, so only one bank stores a word. The same select picks which bank drives the shared read-data bus. The tri-state bus of a programmable fabric is modelled here as a one-hot AND-OR multiplexer.

Depth comes from the number of banks (a power of two, at least two). Width comes from putting several 4-bit cells side by side inside each bank. Those cells share the address and enables, and each holds its own slice of the data word. Reads are combinational. A write takes effect at the rising clock edge. Reset clears every stored word, so the array starts in a known state.

Top module: `banked_ram`

## Requirements
- R1: After reset every address reads back zero on `rdData`.
- R2: Address bits [3:0] select the word inside a bank, and address bits [ADDR_W-1:4] give the bank index. A word written at one address is read back only at that same address.
- R3: Reading is combinational. `rdData` shows the word at the new `addr` within the same clock phase, with no clock edge in between.
- R4: When `wrEn` is high at a rising edge of `clk`, `wrData` is stored at `addr`. It is visible on `rdData` right after that edge.
- R5: A write changes only the selected bank. The same low address in every other bank keeps its contents.
- R6: When `wrEn` is low, a rising edge stores nothing, whatever `addr` and `wrData` hold.
- R7: For every address, exactly one bank select is active, and at most one bank write-port enable is active.
- R8: Each 4-bit slice of a word is stored on its own. Words whose nibbles all differ read back exactly, bit for bit.
- R9: While `addr` is stable and no write happened at the last edge, `rdData` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock |
| rstN | input | 1 | Active-low asynchronous reset; clears all words |
| addr | input | ADDR_W (4+log2 NUM_BANKS) | Shared read/write address |
| wrEn | input | 1 | Write request, sampled at the rising edge |
| wrData | input | DATA_W | Word to store |
| rdData | output | DATA_W | Word at `addr`, combinational |

## Verification
The bench builds the array with four banks and an 8-bit word. This gives a 64-word space with two data slices per bank. With four banks, the decode is a true many-way choice rather than a single address bit. With two slices, a write must move two cells in step while each keeps its own nibble. That geometry lets the bench write the same low address in every bank to show bank isolation. It also lets the bench compare a long pseudo-random run against an associative reference model.

// File: rtl/banked_ram_pkg.sv
package banked_ram_pkg;
  localparam int CELL_AW    = 4;
  localparam int CELL_DEPTH = 1 << CELL_AW;
  localparam int CELL_W     = 4;

  function automatic bit isPow2(input int n);
    return (n > 1) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/ram_cell16.sv
module ram_cell16
  import banked_ram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpe,
  input  logic [CELL_AW-1:0] addr,
  input  logic [CELL_W-1:0]  wd,
  output logic [CELL_W-1:0]  rd
);
  logic [CELL_W-1:0] mem [CELL_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CELL_DEPTH; i++) mem[i] <= '0;
    end else if (wpe) begin
      mem[addr] <= wd;
    end
  end

  assign rd = mem[addr];

  // R5 / R6: a cell whose write-port enable is low keeps the word it was pointing at
  assert_cell_untouched_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wpe |=> mem[$past(addr)] == $past(mem[addr]));
endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl #(
  parameter int  NUM_BANKS = 4,
  parameter type strobes_t = logic,
  localparam int SEL_W     = $clog2(NUM_BANKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] bankIdx,
  input  logic             wrEn,
  output strobes_t         strobes
);
  logic [NUM_BANKS-1:0] bankSel;

  always_comb begin
    bankSel = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      bankSel[b] = (bankIdx == SEL_W'(b));
  end

  always_comb begin
    strobes.bankSel = bankSel;
    strobes.bankWpe = bankSel & {NUM_BANKS{wrEn}};
  end

  // R7: one bank selected for every address, never two write enables
  assert_one_bank_R7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobes.bankSel) == 1);
  assert_wpe_onehot0_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.bankWpe));
endmodule

// File: rtl/bank_array.sv
module bank_array
  import banked_ram_pkg::*;
#(
  parameter int  NUM_BANKS = 4,
  parameter int  DATA_W    = 8,
  parameter type strobes_t = logic,
  localparam int SLICES    = DATA_W / CELL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strobes,
  input  logic [CELL_AW-1:0] addrLo,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData
);
  logic [DATA_W-1:0] bankRd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
      ram_cell16 u_cell (
        .clk  (clk),
        .rstN (rstN),
        .wpe  (strobes.bankWpe[b]),
        .addr (addrLo),
        .wd   (wrData[s*CELL_W +: CELL_W]),
        .rd   (bankRd[b][s*CELL_W +: CELL_W])
      );
    end
  end

  // one-hot AND-OR stands in for the shared tri-state read bus
  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      rdData = rdData | (bankRd[b] & {DATA_W{strobes.bankSel[b]}});
  end
endmodule

// File: rtl/banked_ram.sv
module banked_ram
  import banked_ram_pkg::*;
#(
  parameter int  NUM_BANKS = 4,
  parameter int  DATA_W    = 8,
  localparam int SEL_W     = $clog2(NUM_BANKS),
  localparam int ADDR_W    = CELL_AW + SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  typedef struct packed {
    logic [NUM_BANKS-1:0] bankSel;
    logic [NUM_BANKS-1:0] bankWpe;
  } strobes_t;

  initial begin
    assert_geometry: assert (isPow2(NUM_BANKS) && DATA_W > 0 && (DATA_W % CELL_W) == 0)
      else $error("banked_ram: NUM_BANKS must be a power of two >= 2, DATA_W a multiple of 4");
  end

  strobes_t strobes;

  bank_ctrl #(.NUM_BANKS(NUM_BANKS), .strobes_t(strobes_t)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bankIdx (addr[ADDR_W-1:CELL_AW]),
    .wrEn    (wrEn),
    .strobes (strobes)
  );

  bank_array #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .strobes_t(strobes_t)) u_array (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .addrLo  (addr[CELL_AW-1:0]),
    .wrData  (wrData),
    .rdData  (rdData)
  );

  // R4: a write is read straight back at the same address after the edge
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (addr != $past(addr)) || (rdData == $past(wrData)));
  // R9: quiet address and no write means a quiet read bus
  assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrEn) && $stable(addr)) |-> $stable(rdData));
  // R2: the selected bank is the one named by the upper address bits
  assert_bank_decode_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bankSel[addr[ADDR_W-1:CELL_AW]]);
endmodule

// File: tb/sim_banked_ram.sv
`timescale 1ns/1ps
module sim_banked_ram;
  localparam int NB = 4;
  localparam int DW = 8;
  localparam int AW = 6;
  localparam int WORDS = 64;

  logic clk = 0;
  logic rstN = 0;
  logic [AW-1:0] addr = '0;
  logic wrEn = 0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] model [int];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  banked_ram #(.NUM_BANKS(NB), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [DW-1:0] expect_at(input int a);
    return model.exists(a) ? model[a] : '0;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  task automatic doWrite(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = AW'(a); wrData = d; wrEn = 1;
    @(negedge clk);
    wrEn = 0;
    model[a] = d;
  endtask

  task automatic readCheck(input int a, input string req);
    @(negedge clk);
    addr = AW'(a);
    #1;
    check(req, rdData, expect_at(a));
  endtask

  task automatic testReset();
    for (int a = 0; a < WORDS; a++) readCheck(a, "R1");
  endtask

  task automatic testDecode();
    for (int a = 0; a < WORDS; a++) doWrite(a, DW'(a * 3 + 7));
    for (int a = 0; a < WORDS; a++) readCheck(a, "R2");
  endtask

  task automatic testIsolation();
    for (int lo = 0; lo < 16; lo += 5) begin
      for (int b = 0; b < NB; b++) begin
        doWrite(b * 16 + lo, DW'(8'hA0 + b * 16 + lo));
        for (int o = 0; o < NB; o++) readCheck(o * 16 + lo, "R5");
      end
    end
  endtask

  task automatic testNoWrite();
    for (int a = 0; a < WORDS; a += 9) begin
      @(negedge clk);
      addr = AW'(a); wrData = ~expect_at(a); wrEn = 0;
      @(negedge clk);
      #1;
      check("R6", rdData, expect_at(a));
    end
  endtask

  task automatic testAsyncRead();
    doWrite(3, 8'h5C);
    doWrite(51, 8'hC5);
    @(posedge clk);
    #0.5;
    addr = AW'(3);
    #0.5;
    check("R3", rdData, 8'h5C);
    addr = AW'(51);
    #0.5;
    check("R3", rdData, 8'hC5);
    @(negedge clk);
    #0.5;
    check("R9", rdData, 8'hC5);
    @(negedge clk);
    #0.5;
    check("R9", rdData, 8'hC5);
  endtask

  task automatic testNibbles();
    doWrite(17, 8'h0F);
    doWrite(34, 8'hF0);
    doWrite(60, 8'h96);
    readCheck(17, "R8");
    readCheck(34, "R8");
    readCheck(60, "R8");
    doWrite(60, 8'h69);
    readCheck(60, "R4");
  endtask

  task automatic testRandom();
    for (int i = 0; i < 400; i++) begin
      lfsr = nextRand(lfsr);
      if (lfsr[7]) doWrite(int'(lfsr[AW-1:0]), DW'(lfsr[23:16]));
      else readCheck(int'(lfsr[13:8]), "R4");
    end
    for (int a = 0; a < WORDS; a++) readCheck(a, "R5");
  endtask

  initial begin
    #40000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testDecode();
    testIsolation();
    testNoWrite();
    testAsyncRead();
    testNibbles();
    testRandom();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule